// File: doc/BRIEF.md
# Frame-Alternating Color Level Encoder

This block lets a display path with only one bit per color channel show three intensity levels per channel, and so 27 colors instead of 8. Each incoming pixel carries a requested level of 0, 1 or 2 for each channel. Level 0 drives the channel low and level 2 drives it high. Level 1 drives the channel high on odd frames and low on even frames. Over a two-frame pair the eye averages this to a mid intensity, because the orders high-low and low-high look the same. The block keeps one frame-parity bit. It toggles on every frame-start strobe, so a frame is never split between the two patterns.

Pixels enter on a valid/ready stream and leave on a valid/ready stream through a single register stage. The upstream side may present a pixel whenever it likes. A pixel is taken in a cycle where both `pix_valid` and `pix_ready` are high. `pix_ready` is high when the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the output holds its value and no new pixel is taken. A blanking flag travels with each pixel and forces all of its channel bits low. The frame-start strobe is a plain control pin and does not take part in the handshake.

Top module: `dither_encoder`

## Requirements
- R1: After reset, `out_valid` is 0, `out_rgb` is all zeros, `pix_ready` is 1, and the frame parity is even.
- R2: A channel requested at level 0 produces an output bit of 0 on every frame.
- R3: A channel requested at level 2 produces an output bit of 1 on every frame, unless the pixel is blanked.
- R4: A channel requested at level 3 behaves exactly like level 2.
- R5: A channel requested at level 1 produces 1 while the frame parity is odd and 0 while it is even.
- R6: The frame parity toggles once per cycle in which `frame_tick` is high, and never changes in any other cycle.
- R7: A pixel accepted in the same cycle as `frame_tick` is encoded with the new, already toggled parity.
- R8: A pixel accepted with `pix_blank` high produces all-zero output bits, whatever levels it requests.
- R9: An accepted pixel appears on `out_rgb` with `out_valid` high one clock cycle after acceptance. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_rgb` stay unchanged.
- R10: `pix_ready` equals (not `out_valid`) or `out_ready`. A pixel offered while `pix_ready` is low is not taken and leaves the output unchanged.
- R11: Channel c reads its level from `pix_level[2c+1:2c]` and drives `out_rgb[c]`. Channel 0 is blue, 1 is green, 2 is red. Each channel is encoded independently of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle frame-start strobe; toggles frame parity |
| pix_valid | input | 1 | Input pixel present |
| pix_ready | output | 1 | Block can take the input pixel this cycle |
| pix_level | input | 6 | Requested level per channel, 2 bits each (blue low) |
| pix_blank | input | 1 | Blanking flag travelling with the pixel |
| out_valid | output | 1 | Output register holds a pixel |
| out_ready | input | 1 | Downstream takes the output pixel this cycle |
| out_rgb | output | 3 | Encoded channel bits: [2] red, [1] green, [0] blue |

## Verification
Two functions can fall in the same cycle: the frame-start toggle of the parity and the acceptance of a pixel that requests level 1 on some channel. The bench provokes this coincidence in directed steps and lets random traffic raise `frame_tick` together with `pix_valid` many times. It judges the result against a model that flips its parity before encoding, so the pixel must show the new frame's pattern. A second collision is a new pixel offered while the output stalls. There the bench expects the held value and a low `pix_ready`.

// File: rtl/dith_pkg.sv
package dith_pkg;
  localparam int unsigned LVL_W = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_OFF      = 2'd0,
    LVL_HALF     = 2'd1,
    LVL_FULL     = 2'd2,
    LVL_FULL_ALT = 2'd3
  } level_e;
endpackage

// File: rtl/dith_frame_parity.sv
module dith_frame_parity (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  output logic odd_q,
  output logic odd_eff
);
  // Parity that applies to a pixel taken this cycle: a tick starts the new frame now.
  assign odd_eff = frame_tick ? ~odd_q : odd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) odd_q <= 1'b0;
    else if (frame_tick) odd_q <= ~odd_q;
  end

  AST_PARITY_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(odd_q)); // R6
  AST_PARITY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> (odd_q != $past(odd_q))); // R6
endmodule

// File: rtl/dith_chan_map.sv
module dith_chan_map
  import dith_pkg::*;
(
  input  logic [LVL_W-1:0] level,
  input  logic             odd,
  input  logic             blank,
  output logic             bit_o
);
  level_e lvl;
  assign lvl = level_e'(level);

  always_comb begin
    unique case (lvl)
      LVL_OFF:      bit_o = 1'b0;
      LVL_HALF:     bit_o = odd;
      LVL_FULL,
      LVL_FULL_ALT: bit_o = 1'b1;
      default:      bit_o = 1'b0;
    endcase
    if (blank) bit_o = 1'b0;
  end
endmodule

// File: rtl/dith_out_stage.sv
module dith_out_stage #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  logic take;
  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
  AST_TAKE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (out_valid && out_data == $past(in_data))); // R9
  AST_REFUSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(out_data)); // R10
endmodule

// File: rtl/dither_encoder.sv
module dither_encoder
  import dith_pkg::*;
#(
  parameter int unsigned CHANNELS = 3,
  localparam int unsigned LEVEL_BITS = CHANNELS * LVL_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_tick,
  input  logic                  pix_valid,
  output logic                  pix_ready,
  input  logic [LEVEL_BITS-1:0] pix_level,
  input  logic                  pix_blank,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [CHANNELS-1:0]   out_rgb
);
  logic                odd_q;
  logic                odd_eff;
  logic [CHANNELS-1:0] enc_bits;
  logic                take;

  assign take = pix_valid & pix_ready;

  dith_frame_parity u_parity (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .odd_q      (odd_q),
    .odd_eff    (odd_eff)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    dith_chan_map u_map (
      .level (pix_level[c*LVL_W +: LVL_W]),
      .odd   (odd_eff),
      .blank (pix_blank),
      .bit_o (enc_bits[c])
    );

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (take && pix_level[c*LVL_W +: LVL_W] == 2'd0) |=> !out_rgb[c]); // R2
    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !pix_blank && pix_level[c*LVL_W +: LVL_W] >= 2'd2) |=> out_rgb[c]); // R3
    AST_HALF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !pix_blank && pix_level[c*LVL_W +: LVL_W] == 2'd1) |=> (out_rgb[c] == odd_q)); // R7
  end

  dith_out_stage #(.WIDTH(CHANNELS)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (pix_valid),
    .in_ready  (pix_ready),
    .in_data   (enc_bits),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_rgb)
  );

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pix_blank) |=> (out_rgb == '0)); // R8
endmodule

// File: tb/dither_encoder_test.sv
module dither_encoder_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_tick = 1'b0;
  logic       pix_valid = 1'b0;
  logic       pix_ready;
  logic [5:0] pix_level = '0;
  logic       pix_blank = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [2:0] out_rgb;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  bit       m_par = 1'b0;
  bit       m_valid = 1'b0;
  bit [2:0] m_rgb = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dither_encoder uut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_level(pix_level), .pix_blank(pix_blank),
    .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb)
  );

  function automatic bit enc_one(input bit [1:0] lvl, input bit odd);
    if (lvl == 2'd0) return 1'b0;
    if (lvl == 2'd1) return odd;
    return 1'b1;
  endfunction

  function automatic bit [2:0] enc_pix(input bit [5:0] lvl, input bit blank, input bit odd);
    bit [2:0] r;
    for (int c = 0; c < 3; c++) r[c] = enc_one(lvl[2*c +: 2], odd);
    return blank ? 3'b000 : r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit v, input bit [5:0] lvl,
                      input bit blank, input bit tick, input bit ordy);
    bit acc;
    @(negedge clk);
    pix_valid = v; pix_level = lvl; pix_blank = blank;
    frame_tick = tick; out_ready = ordy;
    #1;
    check("R10 ready", pix_ready, !m_valid || ordy);
    acc = v && (!m_valid || ordy);
    if (tick) m_par = ~m_par;
    if (acc) begin
      m_rgb = enc_pix(lvl, blank, m_par);
      m_valid = 1'b1;
    end else if (ordy) m_valid = 1'b0;
    @(posedge clk);
    #1;
    check({tag, " valid"}, out_valid, m_valid);
    check({tag, " rgb"}, out_rgb, m_rgb);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20517);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 valid", out_valid, 0);
    check("R1 rgb", out_rgb, 0);
    check("R1 ready", pix_ready, 1);

    // R1 parity even: a level-1 pixel with no tick stays low
    step("R1 even", 1, 6'b01_01_01, 0, 0, 1);
    step("R2 off", 1, 6'b00_00_00, 0, 0, 1);
    step("R3 full", 1, 6'b10_10_10, 0, 0, 1);
    step("R4 alt", 1, 6'b11_11_11, 0, 0, 1);
    step("R7 same-cycle tick", 1, 6'b01_01_01, 0, 1, 1);
    step("R6 no tick", 1, 6'b01_01_01, 0, 0, 1);
    step("R5 back to even", 1, 6'b01_01_01, 0, 1, 1);
    step("R6 tick idle", 0, 6'b00_00_00, 0, 1, 1);
    step("R5 odd half", 1, 6'b01_00_01, 0, 0, 1);
    step("R8 blank", 1, 6'b10_11_01, 1, 0, 1);
    step("R11 fields", 1, 6'b10_00_01, 0, 0, 1);
    step("R11 fields b", 1, 6'b00_01_11, 0, 0, 1);
    // stall: output must hold, new pixel refused
    step("R9 load", 1, 6'b10_10_10, 0, 0, 0);
    step("R10 refused", 1, 6'b00_00_00, 0, 0, 0);
    step("R9 held", 1, 6'b00_00_00, 0, 1, 0);
    step("R9 drain+take", 1, 6'b01_01_01, 0, 0, 1);
    step("R9 empty", 0, 6'b00_00_00, 0, 0, 1);

    for (int i = 0; i < 4000; i++) begin
      step("R5 random", ($urandom % 4) != 0, 6'($urandom), ($urandom % 8) == 0,
           ($urandom % 16) == 0, ($urandom % 3) != 0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule